// File: doc/BRIEF.md
# Pseudo-Color Pixel Unpacker with Palette Paging

This block sits between a wide pixel bus and a 256-entry color lookup table. Each word taken from the pixel bus holds several packed pixels, at 1, 2, 4 or 8 bits per pixel. The block emits them one per accepted output cycle as an 8-bit palette index. At the lower depths, the index bits that the pixel does not supply are filled from a page register. Software can therefore pick one of several small palettes inside the larger table. An endianness setting chooses between two orders: fields taken from the least significant end, or the active bus bits mirrored before unpacking. The number of bus bits that carry pixels can be set from 4 up to the full bus width.

A mode bit selects a separate byte-wide pass-through port instead of the pixel bus. Its data and its blank and sync inputs then go straight to the outputs. This is the state after reset.

Both data inputs and the output are valid/ready streams. A beat moves only in a cycle where valid and ready are both high. While out_ready is low, a pending index and its valid flag are held unchanged. pix_ready depends combinationally on out_ready. A new word is taken only when the held word is empty, or when its last pixel leaves in the same cycle. Back-to-back words therefore leave no idle output cycle. Settings are written through a small register port. The unpacker picks them up only when it takes a new word, or while it holds no pixels.

Top module: `pxu_unpack`

## Requirements
- R1: After reset, the block is in pass-through mode at 8 bits per pixel with the full 64-bit bus active, page 0, and least-significant-first order. pix_ready is low.
- R2: Mode register (address 0) bits 1:0 select the depth: 0=1, 1=2, 2=4, 3=8 bits per pixel. Each accepted word yields exactly (active width / depth) indices, after which out_valid falls unless another word was taken.
- R3: The low d bits of each index come from the pixel field, and the upper 8-d bits come from bits 7:d of the page register (address 2). At 8 bits per pixel the page is not used.
- R4: With the order bit (address 3, bit 0) clear, pixel n of a word is bus bits [n*d+d-1 : n*d], so the lowest field comes out first.
- R5: With the order bit set, the active W bits are mirrored before unpacking, so that bit i takes bus bit W-1-i. Fields are then taken lowest first.
- R6: Bus bits at and above the active width have no effect on any index.
- R7: Width register (address 1) bits 2:0 select 4, 8, 16, 32 or 64 active bits for codes 0 to 4. Codes above 4 mean 64. A 4-bit bus combined with 8 bits per pixel is treated as an 8-bit bus.
- R8: pix_ready is high only when no pixel is held, or when exactly one is held and out_ready is high. A stream of 1-pixel words then gives an index every cycle.
- R9: While out_valid is high and out_ready is low, out_valid and out_index hold in the next cycle.
- R10: Register writes do not change the remaining indices of a word already taken. They apply from the next accepted word.
- R11: With mode bit 7 set, out_index, out_valid and the three sync outputs follow the pass-through inputs, vga_ready follows out_ready, and pix_ready stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 mode, 1 width, 2 page, 3 order |
| cfg_wdata | input | 8 | Register write data |
| pix_valid | input | 1 | Pixel word valid |
| pix_ready | output | 1 | Pixel word accepted when high with pix_valid |
| pix_data | input | BUS_W | Packed pixel word |
| vga_valid | input | 1 | Pass-through beat valid |
| vga_ready | output | 1 | Pass-through beat accepted |
| vga_data | input | 8 | Pass-through palette index |
| vga_blank | input | 1 | Pass-through blank |
| vga_hsync | input | 1 | Pass-through horizontal sync |
| vga_vsync | input | 1 | Pass-through vertical sync |
| out_valid | output | 1 | Index valid |
| out_ready | input | 1 | Downstream ready |
| out_index | output | 8 | Palette index |
| out_blank | output | 1 | Blank, pass-through mode only |
| out_hsync | output | 1 | Horizontal sync, pass-through mode only |
| out_vsync | output | 1 | Vertical sync, pass-through mode only |

## Verification
Random words are sent under random depth, width code, page and order settings. Their upper bus bits are random too, so a wrong mask shows up apart from a wrong field order or a wrong page merge. Random output stalls separate correct holding from lost or repeated indices. Directed cases cover the following:
- the reset defaults;
- a page change in the middle of a word, which tells a word-boundary update apart from an immediate one;
- the 4-bit-bus/8-bit-pixel fallback and an out-of-range width code;
- an unbroken stream of one-pixel words, which shows whether the early pix_ready is present;
- the pass-through port.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  localparam int IDX_W = 8;

  localparam logic [1:0] REG_MODE  = 2'd0;
  localparam logic [1:0] REG_WIDTH = 2'd1;
  localparam logic [1:0] REG_PAGE  = 2'd2;
  localparam logic [1:0] REG_ORDER = 2'd3;

  typedef enum logic [1:0] {
    BPP1 = 2'd0,
    BPP2 = 2'd1,
    BPP4 = 2'd2,
    BPP8 = 2'd3
  } bpp_e;

  typedef struct packed {
    logic             vga;
    bpp_e             bpp;
    logic [2:0]       wcode;
    logic [IDX_W-1:0] page;
    logic             big;
  } cfg_t;

  // merge the pixel field under the page prefix
  function automatic logic [IDX_W-1:0] form_index(input logic [IDX_W-1:0] field,
                                                  input bpp_e bpp,
                                                  input logic [IDX_W-1:0] page);
    logic [IDX_W-1:0] r;
    case (bpp)
      BPP1:    r = {page[7:1], field[0]};
      BPP2:    r = {page[7:2], field[1:0]};
      BPP4:    r = {page[7:4], field[3:0]};
      default: r = field;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pxu_cfg.sv
module pxu_cfg
  import pxu_pkg::*;
#(
  parameter logic [2:0] MAX_WCODE = 3'd4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  input  logic       take,
  output cfg_t       nxt,
  output logic       act_vga,
  output bpp_e       act_bpp,
  output logic [7:0] act_page
);
  cfg_t shd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shd.vga   <= 1'b1;
      shd.bpp   <= BPP8;
      shd.wcode <= MAX_WCODE;
      shd.page  <= '0;
      shd.big   <= 1'b0;
    end else if (we) begin
      case (addr)
        REG_MODE: begin
          shd.vga <= wdata[7];
          shd.bpp <= bpp_e'(wdata[1:0]);
        end
        REG_WIDTH: shd.wcode <= wdata[2:0];
        REG_PAGE:  shd.page  <= wdata;
        default:   shd.big   <= wdata[0];
      endcase
    end
  end

  // clamp the width code and resolve the narrow-bus/deep-pixel clash
  always_comb begin
    nxt = shd;
    if (shd.wcode > MAX_WCODE) nxt.wcode = MAX_WCODE;
    if (nxt.wcode == 3'd0 && nxt.bpp == BPP8) nxt.wcode = 3'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_vga  <= 1'b1;
      act_bpp  <= BPP8;
      act_page <= '0;
    end else if (take) begin
      act_vga  <= nxt.vga;
      act_bpp  <= nxt.bpp;
      act_page <= nxt.page;
    end
  end
endmodule

// File: rtl/pxu_prep.sv
module pxu_prep #(
  parameter int BUS_W = 64
) (
  input  logic [BUS_W-1:0] word,
  input  logic [2:0]       wcode,
  input  logic             big,
  output logic [BUS_W-1:0] aligned
);
  localparam int NW = $clog2(BUS_W / 4) + 1;

  logic [NW-1:0][BUS_W-1:0] cand;

  for (genvar k = 0; k < NW; k++) begin : g_width
    localparam int W = 4 << k;
    for (genvar i = 0; i < BUS_W; i++) begin : g_bit
      if (i < W) begin : g_in
        assign cand[k][i] = big ? word[W-1-i] : word[i];
      end else begin : g_out
        assign cand[k][i] = 1'b0;
      end
    end
  end

  always_comb begin
    aligned = cand[NW-1];
    for (int k = 0; k < NW; k++) begin
      if (wcode == 3'(k)) aligned = cand[k];
    end
  end
endmodule

// File: rtl/pxu_shift.sv
module pxu_shift
  import pxu_pkg::*;
#(
  parameter int BUS_W = 64,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BUS_W-1:0] load_word,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic             advance,
  input  bpp_e             bpp,
  output logic [IDX_W-1:0] field,
  output logic [CNT_W-1:0] cnt
);
  logic [BUS_W-1:0] hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold <= '0;
      cnt  <= '0;
    end else if (load) begin
      hold <= load_word;
      cnt  <= load_cnt;
    end else if (advance) begin
      cnt <= cnt - CNT_W'(1);
      case (bpp)
        BPP1:    hold <= hold >> 1;
        BPP2:    hold <= hold >> 2;
        BPP4:    hold <= hold >> 4;
        default: hold <= hold >> 8;
      endcase
    end
  end

  assign field = hold[IDX_W-1:0];
endmodule

// File: rtl/pxu_unpack.sv
module pxu_unpack
  import pxu_pkg::*;
#(
  parameter int BUS_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [7:0]       cfg_wdata,
  input  logic             pix_valid,
  output logic             pix_ready,
  input  logic [BUS_W-1:0] pix_data,
  input  logic             vga_valid,
  output logic             vga_ready,
  input  logic [7:0]       vga_data,
  input  logic             vga_blank,
  input  logic             vga_hsync,
  input  logic             vga_vsync,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_index,
  output logic             out_blank,
  output logic             out_hsync,
  output logic             out_vsync
);
  localparam int         NW        = $clog2(BUS_W / 4) + 1;
  localparam logic [2:0] MAX_WCODE = 3'(NW - 1);
  localparam int         CNT_W     = $clog2(BUS_W) + 1;

  cfg_t             nxt_cfg;
  logic             act_vga;
  bpp_e             act_bpp;
  logic [7:0]       act_page;
  logic             take;
  logic             accept;
  logic             pix_fire;
  logic [BUS_W-1:0] aligned;
  logic [CNT_W-1:0] wbits;
  logic [CNT_W-1:0] ppw;
  logic [CNT_W-1:0] pix_cnt;
  logic [IDX_W-1:0] field;
  logic [IDX_W-1:0] pix_index;

  pxu_cfg #(.MAX_WCODE(MAX_WCODE)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .take     (take),
    .nxt      (nxt_cfg),
    .act_vga  (act_vga),
    .act_bpp  (act_bpp),
    .act_page (act_page)
  );

  pxu_prep #(.BUS_W(BUS_W)) u_prep (
    .word    (pix_data),
    .wcode   (nxt_cfg.wcode),
    .big     (nxt_cfg.big),
    .aligned (aligned)
  );

  assign wbits = CNT_W'(4) << nxt_cfg.wcode;
  assign ppw   = wbits >> nxt_cfg.bpp;

  // a word enters when the holder is empty or drains this cycle
  assign pix_ready = !nxt_cfg.vga && !act_vga &&
                     (pix_cnt == '0 || (pix_cnt == CNT_W'(1) && out_ready));
  assign accept    = pix_valid && pix_ready;
  assign pix_fire  = !act_vga && (pix_cnt != '0) && out_ready;
  assign take      = accept || (pix_cnt == '0);

  pxu_shift #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_word (aligned),
    .load_cnt  (ppw),
    .advance   (pix_fire),
    .bpp       (act_bpp),
    .field     (field),
    .cnt       (pix_cnt)
  );

  assign pix_index = form_index(field, act_bpp, act_page);

  always_comb begin
    if (act_vga) begin
      out_valid = vga_valid;
      out_index = vga_data;
      out_blank = vga_blank;
      out_hsync = vga_hsync;
      out_vsync = vga_vsync;
      vga_ready = out_ready;
    end else begin
      out_valid = (pix_cnt != '0);
      out_index = pix_index;
      out_blank = 1'b0;
      out_hsync = 1'b0;
      out_vsync = 1'b0;
      vga_ready = 1'b0;
    end
  end
endmodule

// File: rtl/pxu_chk.sv
module pxu_chk
  import pxu_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_valid,
  input logic             pix_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_index,
  input logic             act_vga,
  input bpp_e             act_bpp,
  input logic [7:0]       act_page,
  input logic [CNT_W-1:0] pix_cnt
);
  a_r8_load_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> (!out_valid || out_ready));

  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !act_vga) |=> (out_valid && $stable(out_index)));

  a_r3_page_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_vga && out_valid && act_bpp == BPP1) |-> (out_index[7:1] == act_page[7:1]));

  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_cnt > CNT_W'(1)) |=> ($stable(act_page) && $stable(act_bpp) && $stable(act_vga)));

  a_r11_no_pixel_load: assert property (@(posedge clk) disable iff (!rst_n)
    act_vga |-> !pix_ready);

  a_r2_word_yields_index: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready) |=> (out_valid && !act_vga));
endmodule

bind pxu_unpack pxu_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pix_valid (pix_valid),
  .pix_ready (pix_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_index (out_index),
  .act_vga   (act_vga),
  .act_bpp   (act_bpp),
  .act_page  (act_page),
  .pix_cnt   (pix_cnt)
);

// File: tb/pxu_unpack_tb.sv
module pxu_unpack_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        pix_valid = 1'b0;
  logic        pix_ready;
  logic [63:0] pix_data = '0;
  logic        vga_valid = 1'b0;
  logic        vga_ready;
  logic [7:0]  vga_data = '0;
  logic        vga_blank = 1'b0;
  logic        vga_hsync = 1'b0;
  logic        vga_vsync = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_index;
  logic        out_blank;
  logic        out_hsync;
  logic        out_vsync;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // register model
  bit       sh_vga = 1'b1;
  int       sh_bpp = 3;
  int       sh_wc = 4;
  bit [7:0] sh_page = 8'h00;
  bit       sh_big = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  pxu_unpack #(.BUS_W(64)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .vga_valid(vga_valid), .vga_ready(vga_ready), .vga_data(vga_data),
    .vga_blank(vga_blank), .vga_hsync(vga_hsync), .vga_vsync(vga_vsync),
    .out_valid(out_valid), .out_ready(out_ready), .out_index(out_index),
    .out_blank(out_blank), .out_hsync(out_hsync), .out_vsync(out_vsync)
  );

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual %0d expected below 150000", cyc);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int eff_wc(input int wc, input int bpp);
    int r = (wc > 4) ? 4 : wc;
    if (r == 0 && bpp == 3) r = 1;
    return r;
  endfunction

  function automatic int npix(input int wc, input int bpp);
    return (4 << wc) >> bpp;
  endfunction

  function automatic logic [7:0] exp_idx(input logic [63:0] w, input int k, input int bpp,
                                         input int wc, input logic [7:0] page, input bit big);
    int          wbits = 4 << wc;
    int          d = 1 << bpp;
    logic [63:0] a = '0;
    logic [7:0]  mask = 8'((1 << d) - 1);
    logic [7:0]  fld;
    for (int i = 0; i < wbits; i++) a[i] = big ? w[wbits-1-i] : w[i];
    fld = 8'(a >> (k * d)) & mask;
    return (page & ~mask) | fld;
  endfunction

  task automatic write_cfg(input logic [1:0] addr, input logic [7:0] data);
    @(negedge clk);
    out_ready = 1'b0;
    cfg_we = 1'b1; cfg_addr = addr; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    case (addr)
      2'd0: begin sh_vga = data[7]; sh_bpp = int'(data[1:0]); end
      2'd1: sh_wc = int'(data[2:0]);
      2'd2: sh_page = data;
      default: sh_big = data[0];
    endcase
  endtask

  task automatic send(input logic [63:0] w);
    int guard = 0;
    @(negedge clk);
    out_ready = 1'b0;
    pix_data = w; pix_valid = 1'b1;
    while (!pix_ready && guard < 20) begin
      @(negedge clk);
      guard++;
    end
    chk(pix_ready, "R8 word not taken", 64'(pix_ready), 64'h1);
    @(posedge clk);
    #1 pix_valid = 1'b0;
  endtask

  task automatic collect(input logic [63:0] w, input int k0, input int n, input int bpp,
                         input int wc, input logic [7:0] page, input bit big, input string tag,
                         input bit rnd);
    int got = 0;
    while (got < n) begin
      bit rdy;
      logic [7:0] e;
      @(negedge clk);
      rdy = rnd ? (($urandom % 4) != 0) : 1'b1;
      out_ready = rdy;
      e = exp_idx(w, k0 + got, bpp, wc, page, big);
      if (!rdy) chk(out_valid && out_index == e, "R9 stalled index", {out_valid, out_index}, {1'b1, e});
      else chk(out_valid && out_index == e, tag, {out_valid, out_index}, {1'b1, e});
      if (rdy) got++;
    end
  endtask

  task automatic drained();
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid, "R2 extra index after word", 64'(out_valid), 64'h0);
  endtask

  initial begin
    logic [63:0] w;
    int bpp, wc;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    pix_valid = 1'b1; pix_data = 64'hFFFF;
    #1;
    chk(pix_ready == 1'b0, "R1 pix_ready after reset", 64'(pix_ready), 64'h0);
    chk(out_valid == 1'b0, "R1 out_valid follows idle vga_valid", 64'(out_valid), 64'h0);

    // pass-through
    vga_data = 8'h5A; vga_valid = 1'b1; vga_hsync = 1'b1; vga_vsync = 1'b0; vga_blank = 1'b1;
    out_ready = 1'b1;
    #1;
    chk(out_valid && out_index == 8'h5A, "R11 pass-through data", {out_valid, out_index}, {1'b1, 8'h5A});
    chk(out_hsync && out_blank && !out_vsync, "R11 pass-through sync",
        {out_blank, out_hsync, out_vsync}, 3'b110);
    chk(vga_ready == 1'b1, "R11 vga_ready high", 64'(vga_ready), 64'h1);
    chk(pix_ready == 1'b0, "R11 pixel port blocked", 64'(pix_ready), 64'h0);
    out_ready = 1'b0;
    #1;
    chk(vga_ready == 1'b0, "R11 vga_ready follows out_ready", 64'(vga_ready), 64'h0);
    pix_valid = 1'b0; vga_valid = 1'b0; vga_hsync = 1'b0; vga_blank = 1'b0;

    // reset defaults of width, order and depth with pixel mode on
    write_cfg(2'd0, 8'h03);
    w = 64'h0123_4567_89AB_CDEF;
    send(w);
    collect(w, 0, 8, 3, 4, 8'h00, 1'b0, "R1 default 64-bit little-endian", 1'b0);
    drained();

    // page prefix and mid-word change
    write_cfg(2'd2, 8'hA5);
    write_cfg(2'd0, 8'h00);
    w = 64'h8000_0000_0000_0001;
    send(w);
    collect(w, 0, 3, 0, 4, 8'hA5, 1'b0, "R3 page prefix 1bpp", 1'b0);
    write_cfg(2'd2, 8'h3C);
    write_cfg(2'd0, 8'h01);
    collect(w, 3, 61, 0, 4, 8'hA5, 1'b0, "R10 old page kept in word", 1'b0);
    drained();
    w = 64'hFEDC_BA98_7654_3210;
    send(w);
    collect(w, 0, 32, 1, 4, 8'h3C, 1'b0, "R10 new settings next word", 1'b0);
    drained();

    // big-endian, directed
    write_cfg(2'd3, 8'h01);
    write_cfg(2'd0, 8'h02);
    write_cfg(2'd1, 8'h01);
    w = 64'hFFFF_FFFF_FFFF_FF1E;
    send(w);
    collect(w, 0, 2, 2, 1, 8'h3C, 1'b1, "R5 mirrored 8-bit bus", 1'b0);
    drained();

    // 4-bit bus with 8bpp fallback
    write_cfg(2'd3, 8'h00);
    write_cfg(2'd0, 8'h03);
    write_cfg(2'd1, 8'h00);
    w = 64'hFFFF_FFFF_FFFF_FFC7;
    send(w);
    collect(w, 0, 1, 3, 1, 8'h3C, 1'b0, "R7 narrow bus fallback", 1'b0);
    drained();

    // out-of-range width code
    write_cfg(2'd1, 8'h07);
    write_cfg(2'd0, 8'h02);
    w = 64'hA000_0000_0000_0005;
    send(w);
    collect(w, 0, 16, 2, 4, 8'h3C, 1'b0, "R7 code 7 means 64 bits", 1'b0);
    drained();

    // back-to-back single-pixel words
    write_cfg(2'd0, 8'h03);
    write_cfg(2'd1, 8'h01);
    @(negedge clk);
    begin
      logic [63:0] prev = '0;
      out_ready = 1'b1;
      pix_valid = 1'b1;
      for (int i = 0; i < 8; i++) begin
        logic [63:0] nw = {$urandom, $urandom};
        if (i > 0) chk(out_valid && out_index == prev[7:0], "R8 gapless stream",
                       {out_valid, out_index}, {1'b1, prev[7:0]});
        chk(pix_ready, "R8 early ready", 64'(pix_ready), 64'h1);
        pix_data = nw;
        prev = nw;
        @(negedge clk);
      end
      pix_valid = 1'b0;
      chk(out_valid && out_index == prev[7:0], "R8 last of stream", {out_valid, out_index}, {1'b1, prev[7:0]});
    end
    drained();

    // constrained random
    for (int it = 0; it < 120; it++) begin
      string tag;
      write_cfg(2'd0, 8'($urandom % 4));
      write_cfg(2'd1, 8'($urandom % 8));
      write_cfg(2'd2, 8'($urandom));
      write_cfg(2'd3, 8'($urandom % 2));
      bpp = sh_bpp;
      wc = eff_wc(sh_wc, sh_bpp);
      w = {$urandom, $urandom};
      tag = sh_big ? "R5 random mirrored" : (wc < 4 ? "R6 random narrow bus" : "R4 random little-endian");
      send(w);
      collect(w, 0, npix(wc, bpp), bpp, wc, sh_page, sh_big, tag, 1'b1);
      drained();
    end

    finish_run();
  end
endmodule